// File: doc/BRIEF.md
# Power-Up Sequencer with Line Clock

This block runs from a free-running 1 MHz reference clock. It produces three outputs: a line-time-clock square wave near 60 Hz, a DC-good indication, and a power-good indication that follows it. A single divider chain makes the line clock. The same chain also provides the slow time base for sequencing.

The supply-stable input is a digital level from an external comparator. It is first brought into the reference clock domain. While it stays high, a thermometer shift register fills with ones, one stage per line-clock period. DC-good is taken from one stage tap and power-good from a deeper tap. The distance between the taps sets the minimum gap between the two indications. When the supply-stable level falls, the whole register clears at once, so both indications drop together.

With the default values, the divider halves 16660 into two phases of 8330 cycles, which gives about 60.024 Hz. DC-good appears about 15 line periods after the supply is declared stable (at least 3 ms is required). Power-good follows 5 periods later, about 83 ms, against a required minimum of 70 ms.

Top module: `pwrseq_top`

## Requirements
- R1: After a synchronous reset, the line clock, DC-good and power-good are all low, and the divider count restarts from zero.
- R2: The line clock is a 50% duty square wave. It stays low for exactly HALF_DIV reference cycles, then high for exactly HALF_DIV cycles. Its first rise comes HALF_DIV cycles after reset is released.
- R3: The line clock keeps running whatever the level of the supply-stable input.
- R4: If the supply-stable input is raised just after a line-clock rise, DC-good rises 2*HALF_DIV*DC_STAGE + 1 reference cycles later, and power-good rises 2*HALF_DIV*PG_STAGE + 1 cycles later. DC-good comes from stage DC_STAGE and power-good from stage PG_STAGE, counting from 1.
- R5: Power-good is never high while DC-good is low.
- R6: The supply-stable input passes through a two-flop synchronizer. When it falls, both indications stay high for two more reference cycles and are low from the third cycle on.
- R7: If the supply-stable input falls partway through the sequence, all progress is discarded. After it rises again, the full delays of R4 apply from the new rise.
- R8: A one-cycle low pulse on the supply-stable input is treated as a real supply loss. It clears both indications, and the indications come back only after a full new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_stable | input | 1 | Asynchronous digital level, high while the supply is in range |
| line_clk | output | 1 | Divided square wave, about 60 Hz |
| dc_good | output | 1 | DC-good indication |
| power_good | output | 1 | Power-good indication, after DC-good |

## Verification
The bench measures the line clock's high and low runs, both with the supply present and with it absent. A divider that is off by one, or that is gated by the supply, shows up as a wrong run length. The supply is raised just after a line-clock rise, and the exact cycle of each indication rise is compared with the tap formula. A tap taken one stage off, or an extra pipeline register, moves the rise by a whole line period or by one cycle. The bench also checks supply loss in the middle of the sequence, a single-cycle dropout and reset in mid-run. A register that fails to clear completely would bring the indications back early. A design that clears power-good later than DC-good would leave power-good high on its own.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    // Phase of the divided square wave
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } lclk_phase_e;

    // Default sequencing constants (1 MHz reference)
    localparam int unsigned DEF_HALF_DIV = 8330;
    localparam int unsigned DEF_DEPTH    = 20;
    localparam int unsigned DEF_DC_STAGE = 15;
    localparam int unsigned DEF_PG_STAGE = 20;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];

    // R6: output follows the input delayed by exactly STAGES edges
    p_two_flop_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.chain[0]) |=> $rose(st_q.chain[1]));
endmodule

// File: rtl/pwrseq_div.sv
module pwrseq_div
    import pwrseq_pkg::*;
#(
    parameter int unsigned HALF_DIV = DEF_HALF_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic line_clk,
    output logic rise_tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        lclk_phase_e   phase;
        logic          tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        st_d.tick = 1'b0;
        if (wrap) begin
            st_d.cnt = '0;
            if (st_q.phase == PH_LOW) begin
                st_d.phase = PH_HIGH;
                st_d.tick  = 1'b1;
            end else begin
                st_d.phase = PH_LOW;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{cnt: '0, phase: PH_LOW, tick: 1'b0};
        else     st_q <= st_d;
    end

    assign line_clk  = (st_q.phase == PH_HIGH);
    assign rise_tick = st_q.tick;

    // R2: no phase change except at the terminal count
    p_hold_phase_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != LAST) |=> $stable(line_clk));
    // R2: the phase flips at the terminal count
    p_flip_phase_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == LAST) |=> (line_clk != $past(line_clk)));
    // R3: the step pulse marks exactly the rising edge of the line clock
    p_tick_at_rise_r3: assert property (@(posedge clk) disable iff (rst)
        rise_tick |-> (line_clk && !$past(line_clk)));
endmodule

// File: rtl/pwrseq_shift.sv
module pwrseq_shift
    import pwrseq_pkg::*;
#(
    parameter int unsigned DEPTH    = DEF_DEPTH,
    parameter int unsigned DC_STAGE = DEF_DC_STAGE,
    parameter int unsigned PG_STAGE = DEF_PG_STAGE
) (
    input  logic clk,
    input  logic rst,
    input  logic stable,
    input  logic step,
    output logic dc_tap,
    output logic pg_tap
);
    typedef struct packed {
        logic [DEPTH-1:0] stage;
    } shift_state_t;

    shift_state_t st_d, st_q;

    generate
        if (DC_STAGE < 1 || PG_STAGE <= DC_STAGE || PG_STAGE > DEPTH) begin : g_bad_taps
            initial $error("pwrseq_shift: taps must satisfy 1 <= DC_STAGE < PG_STAGE <= DEPTH");
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!stable)
            st_d.stage = '0;
        else if (step)
            st_d.stage = {st_q.stage[DEPTH-2:0], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dc_tap = st_q.stage[DC_STAGE-1];
    assign pg_tap = st_q.stage[PG_STAGE-1];

    // R6: losing the supply empties the register on the next edge
    p_clear_on_loss_r6: assert property (@(posedge clk) disable iff (rst)
        !stable |=> (st_q.stage == '0));
    // R4: contents stay a filled-from-bottom thermometer
    p_thermometer_r4: assert property (@(posedge clk) disable iff (rst)
        ((st_q.stage + 1'b1) & st_q.stage) == '0);
    // R4: no movement without a step while stable
    p_hold_no_step_r4: assert property (@(posedge clk) disable iff (rst)
        (stable && !step) |=> $stable(st_q.stage));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int unsigned HALF_DIV = DEF_HALF_DIV,
    parameter int unsigned DEPTH    = DEF_DEPTH,
    parameter int unsigned DC_STAGE = DEF_DC_STAGE,
    parameter int unsigned PG_STAGE = DEF_PG_STAGE
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_stable,
    output logic line_clk,
    output logic dc_good,
    output logic power_good
);
    logic stable_s;
    logic step;

    pwrseq_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (supply_stable),
        .sync_out (stable_s)
    );

    pwrseq_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .line_clk  (line_clk),
        .rise_tick (step)
    );

    pwrseq_shift #(
        .DEPTH    (DEPTH),
        .DC_STAGE (DC_STAGE),
        .PG_STAGE (PG_STAGE)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .stable (stable_s),
        .step   (step),
        .dc_tap (dc_good),
        .pg_tap (power_good)
    );

    // R5: ordering of the two indications
    p_order_r5: assert property (@(posedge clk) disable iff (rst)
        power_good |-> dc_good);
    // R1: outputs low in the cycle after reset
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> (!line_clk && !dc_good && !power_good));
endmodule

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  H   = 5;
    localparam int  DCS = 3;
    localparam int  PGS = 5;
    localparam int  DEP = 6;
    localparam int  WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_stable = 1'b0;
    logic line_clk, dc_good, power_good;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    pwrseq_top #(.HALF_DIV(H), .DEPTH(DEP), .DC_STAGE(DCS), .PG_STAGE(PGS)) u0 (
        .clk           (clk),
        .rst           (rst),
        .supply_stable (supply_stable),
        .line_clk      (line_clk),
        .dc_good       (dc_good),
        .power_good    (power_good)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        supply_stable = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // wait at negedges until line_clk has just risen
    task automatic align_rise();
        logic prev;
        prev = line_clk;
        forever begin
            @(negedge clk);
            if (line_clk && !prev) break;
            prev = line_clk;
        end
    endtask

    // R1: reset state and first rise timing (R2)
    task automatic t_reset();
        int first;
        do_reset();
        check(line_clk == 1'b0, "R1 line_clk", line_clk, 0);
        check(dc_good == 1'b0, "R1 dc_good", dc_good, 0);
        check(power_good == 1'b0, "R1 power_good", power_good, 0);
        first = 0;
        for (int i = 1; i <= 4*H; i++) begin
            @(negedge clk);
            if (line_clk && first == 0) first = i;
        end
        check(first == H, "R2 first rise", first, H);
    endtask

    // R2/R3: run lengths with a given supply level
    task automatic t_period(input logic sup, input string req);
        int hi, lo;
        supply_stable = sup;
        align_rise();
        hi = 1;
        while (1) begin @(negedge clk); if (!line_clk) break; hi++; end
        lo = 1;
        while (1) begin @(negedge clk); if (line_clk) break; lo++; end
        check(hi == H, {req, " high run"}, hi, H);
        check(lo == H, {req, " low run"}, lo, H);
    endtask

    // R4/R5: exact rise cycles of the indications
    task automatic t_sequence(input string req);
        int dc_at, pg_at;
        bit order_ok;
        align_rise();
        supply_stable = 1'b1;
        dc_at = 0; pg_at = 0; order_ok = 1'b1;
        for (int i = 1; i <= 2*H*PGS + 8; i++) begin
            @(negedge clk);
            if (dc_good && dc_at == 0) dc_at = i;
            if (power_good && pg_at == 0) pg_at = i;
            if (power_good && !dc_good) order_ok = 1'b0;
        end
        check(dc_at == 2*H*DCS + 1, {req, " dc_good rise"}, dc_at, 2*H*DCS + 1);
        check(pg_at == 2*H*PGS + 1, {req, " power_good rise"}, pg_at, 2*H*PGS + 1);
        check(order_ok, "R5 order", order_ok, 1);
    endtask

    // R6: drop latency
    task automatic t_drop();
        supply_stable = 1'b0;
        @(negedge clk);
        check(dc_good && power_good, "R6 high after 1", {dc_good, power_good}, 3);
        @(negedge clk);
        check(dc_good && power_good, "R6 high after 2", {dc_good, power_good}, 3);
        @(negedge clk);
        check(!dc_good && !power_good, "R6 low after 3", {dc_good, power_good}, 0);
    endtask

    // R7: loss mid-sequence, then full restart
    task automatic t_midloss();
        bit stayed_low;
        supply_stable = 1'b0;
        repeat (4) @(negedge clk);
        align_rise();
        supply_stable = 1'b1;
        repeat (2*H*DCS + 3) @(negedge clk);
        check(dc_good && !power_good, "R7 midway state", {dc_good, power_good}, 2);
        supply_stable = 1'b0;
        stayed_low = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2*H*4; i++) begin
            @(negedge clk);
            if (dc_good || power_good) stayed_low = 1'b0;
        end
        check(stayed_low, "R7 no progress kept", stayed_low, 1);
        t_sequence("R7");
    endtask

    // R8: single-cycle dropout
    task automatic t_glitch();
        bit low_seen;
        supply_stable = 1'b0;
        @(negedge clk);
        supply_stable = 1'b1;
        low_seen = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (!dc_good && !power_good) low_seen = 1'b1;
        end
        check(low_seen, "R8 glitch clears", low_seen, 1);
        check(!dc_good, "R8 not back early", dc_good, 0);
        supply_stable = 1'b0;
        repeat (4) @(negedge clk);
        t_sequence("R8");
    endtask

    // R1: reset in mid-run
    task automatic t_midreset();
        do_reset();
        check(!dc_good && !power_good && !line_clk, "R1 midrun reset",
              {line_clk, dc_good, power_good}, 0);
    endtask

    initial begin
        t_reset();
        t_period(1'b0, "R2");
        t_period(1'b0, "R3 supply low");
        t_sequence("R4");
        t_period(1'b1, "R3 supply high");
        t_drop();
        t_midloss();
        t_glitch();
        t_midreset();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule